// File: doc/BRIEF.md
# Serial Memory Slave Hold Sequencer

This block sits in the pin front end of a serial-peripheral memory slave. It decides when a serial transfer is paused and when it resumes. A fast internal clock samples the chip-select, hold, serial-clock and serial-input pins through synchronizers. The block follows them with a three-state sequencer: idle, active and held. Hold is entered and left only at points where the serial clock is low. When the hold pin changes while the clock is high, the change takes effect at the next clock-low point.

While held, serial-clock edges are ignored, the shift gate is closed and the data-out driver is disabled. The bit counter and the partly shifted word are kept, so the transfer continues exactly where it paused. Raising chip select at any time, including during hold, returns the block to idle and discards the partial transfer. The command decoder supplies a read-phase flag, and the block combines it with the hold state to produce the output-enable.

Top module: `sfl_hold_seq`

## Requirements
- R1: After reset, hold_flag, shift_en and so_oe are 0, bit_cnt is 0 and shift_data is 0.
- R2: With chip select low (cs_n_pin=0) and the serial clock low, a low level on hold_n_pin sets hold_flag within six system clocks. This also applies when hold_n_pin was already low when chip select was asserted.
- R3: If hold_n_pin goes low while the serial clock is high, hold_flag stays 0 until the serial clock next goes low, and is then set.
- R4: With hold_flag set, hold_n_pin high while the serial clock is low clears hold_flag. If the clock is high when hold_n_pin rises, hold_flag stays set until the clock next goes low.
- R5: While hold_flag is set, serial-clock rising edges produce no shift_en pulse, and bit_cnt and shift_data do not change whatever si_pin carries.
- R6: so_oe equals read_phase while chip select is low and hold_flag is 0, and is 0 otherwise.
- R7: A high level on cs_n_pin clears hold_flag, bit_cnt and shift_data, whatever the level of hold_n_pin.
- R8: bit_cnt and shift_data are preserved across a hold, and shifting resumes from them after the hold ends.
- R9: Each serial-clock rising edge seen while chip select is low and not held gives a one-cycle shift_en pulse. On that pulse, si_pin is shifted into shift_data bit 0 and the older bits move one position toward the MSB. bit_cnt also increments, wrapping from DATA_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n_pin | input | 1 | Chip select pin, active low, asynchronous |
| hold_n_pin | input | 1 | Hold request pin, active low, asynchronous |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| si_pin | input | 1 | Serial data input pin, asynchronous |
| read_phase | input | 1 | Command decoder flags a read phase (data-out wanted) |
| hold_flag | output | 1 | Transfer is paused |
| shift_en | output | 1 | One-cycle gate for each accepted serial-clock rising edge |
| so_oe | output | 1 | Output-enable for the serial data-out driver |
| bit_cnt | output | CNT_W | Bit position within the current word |
| shift_data | output | DATA_W | Partly shifted word, newest bit in bit 0 |

## Verification
A sequencer that enters or leaves hold on the wrong clock phase shows up as hold_flag changing while the synchronized serial clock is high. The bench sees this at the next settle point, a few system clocks after the pin change. A hold state that leaks into the shift path appears at the ports as an extra or missing shift_en pulse. It also shows as a bit_cnt or shift_data value that differs from the model by the next serial-clock edge. Failing to preserve or to clear the transfer state appears after the next hold exit or chip-select release, as a count that does not continue from the model or does not return to zero.

// File: rtl/sfl_hold_pkg.sv
package sfl_hold_pkg;
  localparam int PIN_CS   = 0;
  localparam int PIN_HOLD = 1;
  localparam int PIN_SCK  = 2;
  localparam int PIN_SI   = 3;
  localparam int PIN_N    = 4;
  // idle pin levels: chip select high, hold high, clock low, data low
  localparam logic [PIN_N-1:0] PIN_IDLE = 4'b0011;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_ACTIVE = 2'd1,
    HS_HELD   = 2'd2
  } hold_st_e;
endpackage

// File: rtl/sfl_pin_sync.sv
module sfl_pin_sync #(
  parameter int          N      = 4,
  parameter int          STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [N-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sfl_hold_fsm.sv
module sfl_hold_fsm
  import sfl_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic hold_n_s,
  input  logic sck_s,
  output logic held,
  output logic shift_en
);
  hold_st_e st_q, st_d;
  logic     sck_d_q;
  logic     sck_rise;

  always_comb begin
    st_d = st_q;
    case (st_q)
      HS_IDLE:   if (!cs_n_s) st_d = HS_ACTIVE;
      HS_ACTIVE: begin
        if (cs_n_s)                  st_d = HS_IDLE;
        else if (!hold_n_s && !sck_s) st_d = HS_HELD;
      end
      HS_HELD: begin
        if (cs_n_s)                  st_d = HS_IDLE;
        else if (hold_n_s && !sck_s) st_d = HS_ACTIVE;
      end
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= HS_IDLE;
      sck_d_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      sck_d_q <= sck_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d_q;
  assign held     = (st_q == HS_HELD);
  assign shift_en = sck_rise & ~cs_n_s & (st_q == HS_ACTIVE);
endmodule

// File: rtl/sfl_shift_track.sv
module sfl_shift_track #(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              si_s,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] shift_data
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    cnt_d  = cnt_q;
    data_d = data_q;
    if (clear) begin
      cnt_d  = '0;
      data_d = '0;
    end else if (shift_en) begin
      cnt_d  = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      data_d = {data_q[DATA_W-2:0], si_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else if (clear || shift_en) begin
      cnt_q  <= cnt_d;
      data_q <= data_d;
    end
  end

  assign bit_cnt    = cnt_q;
  assign shift_data = data_q;
endmodule

// File: rtl/sfl_hold_seq.sv
module sfl_hold_seq
  import sfl_hold_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_pin,
  input  logic              hold_n_pin,
  input  logic              sck_pin,
  input  logic              si_pin,
  input  logic              read_phase,
  output logic              hold_flag,
  output logic              shift_en,
  output logic              so_oe,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] shift_data
);
  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [PIN_N-1:0] pins_raw, pins_s;
  logic             cs_n_s, hold_n_s, sck_s, si_s;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_CS]   = cs_n_pin;
    pins_raw[PIN_HOLD] = hold_n_pin;
    pins_raw[PIN_SCK]  = sck_pin;
    pins_raw[PIN_SI]   = si_pin;
  end

  sfl_pin_sync #(
    .N      (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d    (pins_raw),
    .q    (pins_s)
  );

  assign cs_n_s   = pins_s[PIN_CS];
  assign hold_n_s = pins_s[PIN_HOLD];
  assign sck_s    = pins_s[PIN_SCK];
  assign si_s     = pins_s[PIN_SI];

  sfl_hold_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cs_n_s  (cs_n_s),
    .hold_n_s(hold_n_s),
    .sck_s   (sck_s),
    .held    (hold_flag),
    .shift_en(shift_en)
  );

  sfl_shift_track #(
    .DATA_W(DATA_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clear     (cs_n_s),
    .shift_en  (shift_en),
    .si_s      (si_s),
    .bit_cnt   (bit_cnt),
    .shift_data(shift_data)
  );

  assign so_oe = read_phase & ~cs_n_s & ~hold_flag;
endmodule

// File: rtl/sfl_hold_sva.sv
module sfl_hold_sva #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_s,
  input logic             sck_s,
  input logic             hold_flag,
  input logic             shift_en,
  input logic             so_oe,
  input logic [CNT_W-1:0] bit_cnt
);
  AST_ENTER_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_flag) |-> $past(!sck_s && !cs_n_s)); // R2

  AST_EXIT_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_flag) |-> $past(cs_n_s || !sck_s)); // R4

  AST_NO_SHIFT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_flag |-> !shift_en); // R5

  AST_OE_OFF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_flag |-> !so_oe); // R6

  AST_CS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (!hold_flag && bit_cnt == '0)); // R7

  AST_CNT_KEPT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_flag && !cs_n_s) |=> $stable(bit_cnt)); // R8

  AST_SHIFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !shift_en); // R9
endmodule

bind sfl_hold_seq sfl_hold_sva #(.CNT_W(CNT_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .cs_n_s   (cs_n_s),
  .sck_s    (sck_s),
  .hold_flag(hold_flag),
  .shift_en (shift_en),
  .so_oe    (so_oe),
  .bit_cnt  (bit_cnt)
);

// File: tb/sim_sfl_hold_seq.sv
`timescale 1ns/1ps
module sim_sfl_hold_seq;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 3;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, hold_n = 1'b1, sck = 1'b0, si = 1'b0, rd = 1'b0;
  logic              hold_flag, shift_en, so_oe;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shift_data;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  // reference model state
  bit               m_held;
  logic [CNT_W-1:0] m_cnt;
  logic [DATA_W-1:0] m_data;

  always #4 clk = ~clk;

  sfl_hold_seq #(.DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .hold_n_pin(hold_n),
    .sck_pin(sck), .si_pin(si), .read_phase(rd),
    .hold_flag(hold_flag), .shift_en(shift_en), .so_oe(so_oe),
    .bit_cnt(bit_cnt), .shift_data(shift_data)
  );

  always @(negedge clk) if (shift_en) pulses++;

  function automatic logic [CNT_W-1:0] next_cnt(logic [CNT_W-1:0] c);
    return (c == CNT_W'(DATA_W - 1)) ? '0 : c + 1'b1;
  endfunction

  function automatic bit exp_oe(bit r, bit c, bit h);
    return r && !c && !h;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " hold_flag"}, 32'(hold_flag), 32'(m_held));
    chk({req, " bit_cnt"}, 32'(bit_cnt), 32'(m_cnt));
    chk({req, " shift_data"}, 32'(shift_data), 32'(m_data));
    chk({req, " so_oe R6"}, 32'(so_oe), 32'(exp_oe(rd, cs_n, m_held)));
  endtask

  // model update after a single pin change
  task automatic model(bit sck_rose);
    if (cs_n) begin
      m_held = 0; m_cnt = '0; m_data = '0;
    end else begin
      if (sck_rose && !m_held) begin
        m_data = {m_data[DATA_W-2:0], si};
        m_cnt  = next_cnt(m_cnt);
      end
      if (!m_held && !hold_n && !sck) m_held = 1;
      else if (m_held && hold_n && !sck) m_held = 0;
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  // step kinds: 0 sck toggle, 1 hold toggle, 2 cs toggle
  task automatic step(int kind, bit si_v, string req);
    bit rose;
    int p0;
    rose = 0;
    @(negedge clk);
    p0 = pulses;
    case (kind)
      0: begin
        if (sck) sck = 0;
        else begin si = si_v; sck = 1; rose = 1; end
      end
      1: hold_n = ~hold_n;
      default: cs_n = ~cs_n;
    endcase
    settle();
    model(rose);
    check_all(req);
    chk({req, " shift_en pulses R9"}, 32'(pulses - p0),
        32'(rose && !cs_n && !m_held ? 1 : 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_held = 0; m_cnt = '0; m_data = '0;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    chk("R1 hold_flag", 32'(hold_flag), 0);
    chk("R1 shift_en", 32'(shift_en), 0);
    chk("R1 so_oe", 32'(so_oe), 0);
    chk("R1 bit_cnt", 32'(bit_cnt), 0);
    chk("R1 shift_data", 32'(shift_data), 0);

    // select, shift three bits 1,0,1
    step(2, 0, "R9 select");
    step(0, 1, "R9"); step(0, 0, "R9");
    step(0, 0, "R9"); step(0, 0, "R9");
    step(0, 1, "R9"); step(0, 0, "R9");
    chk("R9 cnt after 3", 32'(bit_cnt), 3);
    chk("R9 data after 3", 32'(shift_data), 32'h5);
    rd = 1;
    step(1, 0, "R2 hold while sck low");
    chk("R2 entered", 32'(hold_flag), 1);
    chk("R6 oe off while held", 32'(so_oe), 0);
    // R5 clock edges while held ignored
    step(0, 1, "R5"); step(0, 0, "R5");
    step(0, 1, "R5");
    chk("R5 cnt frozen", 32'(bit_cnt), 3);
    // R4 release while sck high: deferred
    step(1, 0, "R4 release sck high");
    chk("R4 still held", 32'(hold_flag), 1);
    step(0, 0, "R4 sck falls");
    chk("R4 released", 32'(hold_flag), 0);
    chk("R6 oe back", 32'(so_oe), 1);
    // R8 resume from kept state
    step(0, 1, "R8"); step(0, 0, "R8");
    chk("R8 cnt resumed", 32'(bit_cnt), 4);
    chk("R8 data resumed", 32'(shift_data), 32'hB);
    // R3 hold falls while sck high
    step(0, 0, "R3 sck high");
    step(1, 0, "R3 hold falls sck high");
    chk("R3 not yet held", 32'(hold_flag), 0);
    step(0, 0, "R3 sck falls");
    chk("R3 held", 32'(hold_flag), 1);
    // R7 cs high during hold
    step(2, 0, "R7 cs high in hold");
    chk("R7 hold cleared", 32'(hold_flag), 0);
    chk("R7 cnt cleared", 32'(bit_cnt), 0);
    chk("R7 data cleared", 32'(shift_data), 0);
    // R2 hold already low at select
    step(2, 0, "R2 select with hold low");
    chk("R2 held at select", 32'(hold_flag), 1);
    step(1, 0, "R4 release sck low");
    chk("R4 release low", 32'(hold_flag), 0);

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = $urandom_range(0, 15);
      rd = 1'($urandom_range(0, 1));
      if (r == 0)      step(2, 0, "R7 random");
      else if (r < 5)  step(1, 0, "R2/R4 random");
      else             step(0, 1'($urandom_range(0, 1)), "R5/R9 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule